// File: doc/BRIEF.md
# Boot-time ROM overlay decoder

This block is memory-map glue for a processor with a 20-bit byte address bus. Right after reset the processor fetches its reset vectors and first instructions from address zero, so the block maps firmware ROM there for a short boot window. When that window closes, address zero and the rest of the low region switch to static RAM. The interrupt vector table can then be rewritten at run time. Firmware ROM is also decoded at all times in the highest 64 KiB of the 1 MiB space, and the boot code jumps there before the window closes.

The window is timed by a free-running divide-by-256 counter. The counter is held at zero during reset and starts counting clock edges once reset has left the two-stage reset synchronizer. Its top bit is brought out as a clock divided by 256, which can drive the strobe input of an external watchdog. A sticky overlay flag drops the first time that bit rises. Later wraps of the counter therefore never bring ROM back to address zero.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, the divider is held at zero (`clk_div256` low) and the overlay is active.
- R2: From the third rising edge after reset release the divider counts every clock. `clk_div256` is low for the first 128 counts, high for the next 128, and keeps toggling with a period of 256 clocks.
- R3: While the overlay is active, a strobed access whose address bits 19..16 are all zero drives `rom_cs_n` low and keeps `ram_cs_n` high.
- R4: The overlay ends on the edge where `clk_div256` first rises. It stays ended through every later counter wrap until the next reset.
- R5: Outside the overlay window, a strobed access with address bit 19 equal to 0 (0x00000..0x7FFFF) drives `ram_cs_n` low. While the overlay is active, this applies only above 0x0FFFF.
- R6: A strobed access with address bits 19..16 all ones (0xF0000..0xFFFFF) drives `rom_cs_n` low in every state.
- R7: Strobed accesses in 0x80000..0xEFFFF assert neither select.
- R8: While `as_n` is high, both `rom_cs_n` and `ram_cs_n` are high.
- R9: `rom_cs_n` and `ram_cs_n` are never low together.
- R10: Whenever ROM is selected, `rom_addr` equals address bits 15..0. The overlay alias at zero and the top window therefore reach the same ROM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released through an internal synchronizer |
| addr | input | 20 | Processor byte address |
| as_n | input | 1 | Active-low address strobe |
| rom_cs_n | output | 1 | Active-low firmware ROM select |
| ram_cs_n | output | 1 | Active-low static RAM select |
| rom_addr | output | 16 | Address presented to the ROM |
| clk_div256 | output | 1 | Clock divided by 256 (divider top bit) |

## Verification
The chip selects and `rom_addr` are combinational in the address, the strobe and the registered overlay flag. They are due in the same cycle as the address, and the bench drives new inputs on each falling edge and compares before the next falling edge. `clk_div256` and the overlay flag move only on rising edges. The divider first counts on the third rising edge after reset release, so the overlay falls on the 130th edge after release. A reference model counts edges since release and derives every expected value from that count. A second reset is applied mid-run, after the divider has wrapped, to show that the window reopens only through reset.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

  // Which device a decoded access targets.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAM  = 2'd2
  } sel_e;

  // Address regions seen by the decoder.
  typedef struct packed {
    logic top_win;   // highest ROM-sized window
    logic low_win;   // lowest ROM-sized window (overlay alias)
    logic ram_win;   // static RAM region
  } region_t;

endpackage

// File: rtl/bo_rst_sync.sv
module bo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_no = shift_q[STAGES-1];

endmodule

// File: rtl/bo_div_counter.sv
module bo_div_counter #(
  parameter int DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o,
  output logic overlay_o
);

  localparam int MSB = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;
  logic             ovl_q;
  logic             ovl_d;
  logic             ovl_en;

  // Next state
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + 1'b1;
    ovl_en = ovl_q;
    ovl_d  = ovl_q & ~cnt_d[MSB];
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovl_q <= 1'b1;
    end else if (ovl_en) begin
      ovl_q <= ovl_d;
    end
  end

  assign div_o     = cnt_q[MSB];
  assign overlay_o = ovl_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_OVL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl_q |=> !ovl_q); // R4
  AST_OVL_ENDS_AT_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt_q[MSB]) |-> !ovl_q); // R4

endmodule

// File: rtl/bo_addr_decode.sv
module bo_addr_decode
  import boot_map_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int ROM_AW = 16,
  parameter int RAM_AW = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              overlay_i,
  output logic              rom_cs_no,
  output logic              ram_cs_no,
  output logic [ROM_AW-1:0] rom_addr_o
);

  localparam int HI_W  = ADDR_W - ROM_AW;
  localparam int RHI_W = ADDR_W - RAM_AW;

  logic [HI_W-1:0]  hi_bits;
  logic [RHI_W-1:0] ram_hi_bits;
  region_t          reg_hit;
  sel_e             sel;

  always_comb begin
    hi_bits         = addr_i[ADDR_W-1:ROM_AW];
    ram_hi_bits     = addr_i[ADDR_W-1:RAM_AW];
    reg_hit.top_win = &hi_bits;
    reg_hit.low_win = ~|hi_bits;
    reg_hit.ram_win = ~|ram_hi_bits;
  end

  // Priority: top window, then overlay alias, then RAM.
  always_comb begin
    sel = SEL_NONE;
    if (!as_ni) begin
      if (reg_hit.top_win) begin
        sel = SEL_ROM;
      end else if (reg_hit.low_win && overlay_i) begin
        sel = SEL_ROM;
      end else if (reg_hit.ram_win) begin
        sel = SEL_RAM;
      end
    end
  end

  assign rom_cs_no  = (sel != SEL_ROM);
  assign ram_cs_no  = (sel != SEL_RAM);
  assign rom_addr_o = addr_i[ROM_AW-1:0];

  always_comb begin
    AST_SEL_EXCL: assert (rom_cs_no || ram_cs_no); // R9
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder #(
  parameter int ADDR_W    = 20,
  parameter int ROM_AW    = 16,
  parameter int RAM_AW    = 19,
  parameter int DIV_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              clk_div256
);

  logic rst_sync_n;
  logic overlay;

  bo_rst_sync #(
    .STAGES (SYNC_STGS)
  ) u_rst_sync (
    .clk_i   (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  bo_div_counter #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk_i     (clk),
    .rst_ni    (rst_sync_n),
    .div_o     (clk_div256),
    .overlay_o (overlay)
  );

  bo_addr_decode #(
    .ADDR_W (ADDR_W),
    .ROM_AW (ROM_AW),
    .RAM_AW (RAM_AW)
  ) u_dec (
    .addr_i     (addr),
    .as_ni      (as_n),
    .overlay_i  (overlay),
    .rom_cs_no  (rom_cs_n),
    .ram_cs_no  (ram_cs_n),
    .rom_addr_o (rom_addr)
  );

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (rom_cs_n && ram_cs_n)); // R8
  AST_TOP_IS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && (&addr[ADDR_W-1:ROM_AW])) |-> !rom_cs_n); // R6
  AST_RESET_HOLDS_DIV: assert property (@(posedge clk)
    !rst_sync_n |-> !clk_div256); // R1

endmodule

// File: tb/tb_boot_overlay_decoder.sv
module tb_boot_overlay_decoder;

  logic        clk;
  logic        rst_n;
  logic [19:0] addr;
  logic        as_n;
  logic        rom_cs_n;
  logic        ram_cs_n;
  logic [15:0] rom_addr;
  logic        clk_div256;

  int vectors;
  int miscompares;
  int k;  // rising edges since reset release

  boot_overlay_decoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .as_n       (as_n),
    .rom_cs_n   (rom_cs_n),
    .ram_cs_n   (ram_cs_n),
    .rom_addr   (rom_addr),
    .clk_div256 (clk_div256)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference: edge count since release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b (addr %h as_n %b k %0d)",
               req, what, act, exp, addr, as_n, k);
    end
  endtask

  task automatic compare();
    int   cnt;
    logic ovl, top, low, ramw, e_rom, e_ram, e_div;
    string tag;
    cnt   = (k < 2) ? 0 : ((k - 2) % 256);
    ovl   = (k < 130);
    e_div = (cnt >= 128);
    top   = (addr[19:16] == 4'hF);
    low   = (addr[19:16] == 4'h0);
    ramw  = !addr[19];
    e_rom = !as_n && (top || (ovl && low));
    e_ram = !as_n && ramw && !(ovl && low);
    if (as_n)              tag = "R8";
    else if (top)          tag = "R6";
    else if (low && ovl)   tag = "R3";
    else if (low && k >= 130) tag = "R4";
    else if (ramw)         tag = "R5";
    else                   tag = "R7";
    chk(clk_div256, e_div, (k < 2) ? "R1" : "R2", "clk_div256");
    chk(rom_cs_n, !e_rom, tag, "rom_cs_n");
    chk(ram_cs_n, !e_ram, tag, "ram_cs_n");
    chk(rom_cs_n | ram_cs_n, 1'b1, "R9", "not both selects");
    if (e_rom) begin
      vectors++;
      if (rom_addr !== addr[15:0]) begin
        miscompares++;
        $display("FAIL R10 rom_addr: actual %h expected %h", rom_addr, addr[15:0]);
      end
    end
  endtask

  task automatic drive();
    int r;
    r = $urandom % 6;
    case (r)
      0: addr = {4'h0, 16'($urandom)};
      1: addr = {4'hF, 16'($urandom)};
      2: addr = {1'b0, 3'($urandom % 7 + 1), 16'($urandom)};
      3: addr = {4'h8 + 4'($urandom % 7), 16'($urandom)};
      4: addr = 20'h00000;
      default: addr = 20'($urandom);
    endcase
    as_n = (($urandom % 5) == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      drive();
    end
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    rst_n = 1'b0;
    as_n  = 1'b0;
    addr  = 20'h00010;
    // R1: reset state, ROM at zero during reset
    run(4);
    rst_n = 1'b1;
    run(700);
    // Second reset after wraps: window must reopen (R1, R3, R4)
    @(negedge clk);
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    run(300);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule